// File: doc/BRIEF.md
# Pattern Fill-and-Verify Memory Sequencer

This block is a built-in self-test engine for a word-addressed memory. After a start request it runs a fixed list of test cases over a region given as a byte base address and a byte size. Each case has two phases. First it writes every 32-bit word of the current span with a generated value. Then it reads the span back one word at a time and compares each word with the value the same generator gives for that position. The engine stops at the first word that differs and captures where the error was, the value it wrote and the value it read back.

Two coverage modes are available. The slow mode treats the whole region as one span. The quick mode treats each whole segment of the region (1 MiB by default) as a unit and tests two short windows inside it: one at the start of the segment and one that ends at the segment's upper edge. While it runs, the engine raises a keep-alive pulse at regular word intervals so that an external watchdog can see progress during long passes.

The memory port issues one access per cycle with a `mem_en` strobe and a write select. Read data must come back on the cycle after the read request.

Top module: `mem_pattern_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `fail`, `mem_en` and `keepalive` are all 0.
- R2: The cases run in this order: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, a walking one (1 << (k mod 32)), the index k, and the inverse ~k. Here k is the word index zero-extended to 32 bits.
- R3: In each case the engine writes words k = 0..N-1 of the span at byte address span_start + 4k, in ascending order. It then reads the same words in the same order. Each read is followed by one cycle with no access, in which the returned word is compared.
- R4: In slow mode the span is the whole region: it starts at `base_addr` and holds N = floor(`region_bytes`/4) words. All seven cases run once over it.
- R5: In quick mode, for each whole segment s (s = 0 .. floor(`region_bytes` / 2^SEG_SHIFT) - 1), two spans of WIN_BYTES/4 words each run the full case list. The low span starts at base + s*2^SEG_SHIFT and runs first. The high span starts at base + s*2^SEG_SHIFT + 2^SEG_SHIFT - WIN_BYTES.
- R6: The index k that drives the walking-one, index and inverse-index patterns restarts at 0 at the start of every span.
- R7: `keepalive` is high exactly in the access cycles (write or read) whose word index k is a multiple of 2^KA_LOG. It is low in every other cycle.
- R8: On the first mismatch the engine issues no further access and runs no later case. `fail_addr` holds the byte address of the failing word, `fail_exp` the value written there and `fail_got` the value read.
- R9: `fail` and the captured failure fields keep their values until the next accepted start. An accepted start clears `fail`.
- R10: `done` is a one-cycle pulse at the end of a run, and `busy` is low in that cycle. `busy` is high from the cycle after an accepted start until the run ends. After a failing run, `done` and the rising `fail` appear in the same cycle.
- R11: A `start` pulse while `busy` is high is ignored: the access sequence and the latched mode, base and size do not change.
- R12: A region with no span to test (slow mode with fewer than 4 bytes, or quick mode with less than one segment) gives a `done` pulse in the cycle after start, with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only when idle |
| slow_mode | input | 1 | 1 = whole region, 0 = two windows per segment |
| base_addr | input | ADDR_W | Byte address where the region begins |
| region_bytes | input | ADDR_W | Region size in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| keepalive | output | 1 | Progress pulse |
| fail | output | 1 | Sticky failure flag |
| fail_addr | output | ADDR_W | Byte address of the first failing word |
| fail_exp | output | 32 | Value expected at the failing word |
| fail_got | output | 32 | Value read at the failing word |

## Verification
The end of a run and the capture of a failure can happen in the same cycle when the mismatch is on the very last word of the last case of the last span. The bench provokes this with a data-dependent read fault. The fault flips bit 0 only when the stored value equals ~7 at the last word of the last high window in quick mode, so every earlier compare passes. The bench then judges that `done` is high at the first sample where `fail` is high, that `fail` was low one sample earlier, and that the captured address and values are right. The same check is repeated for faults that stop the run early, together with an exact count of the accesses issued before the stop.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    PAT_ZERO   = 3'd0,
    PAT_ONES   = 3'd1,
    PAT_ALT01  = 3'd2,
    PAT_ALT10  = 3'd3,
    PAT_WALK   = 3'd4,
    PAT_INDEX  = 3'd5,
    PAT_NINDEX = 3'd6
  } pat_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_READ  = 2'd2,
    ST_CHECK = 2'd3
  } seq_st_t;
endpackage

// File: rtl/msq_pattern_gen.sv
module msq_pattern_gen
  import msq_pkg::*;
#(
  parameter int IDX_W = 30
) (
  input  pat_sel_t              sel,
  input  logic [IDX_W-1:0]      idx,
  output logic [WORD_W-1:0]     word
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] idx_w;
  assign idx_w = WORD_W'(idx);

  always_comb begin
    unique case (sel)
      PAT_ZERO:   word = '0;
      PAT_ONES:   word = '1;
      PAT_ALT01:  word = {(WORD_W/2){2'b01}};
      PAT_ALT10:  word = {(WORD_W/2){2'b10}};
      PAT_WALK:   word = WORD_W'(1) << idx_w[BIT_W-1:0];
      PAT_INDEX:  word = idx_w;
      PAT_NINDEX: word = ~idx_w;
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/msq_span_plan.sv
module msq_span_plan #(
  parameter int ADDR_W    = 32,
  parameter int SEG_SHIFT = 20,
  parameter int WIN_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              slow_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] size_in,
  input  logic              advance,
  output logic              empty_in,
  output logic [ADDR_W-1:0] span_base,
  output logic [ADDR_W-3:0] span_words,
  output logic              last_span
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int SEG_W     = ADDR_W - SEG_SHIFT;
  localparam int WIN_WORDS = WIN_BYTES / 4;
  localparam int HI_OFF    = (1 << SEG_SHIFT) - WIN_BYTES;

  logic              slow_q, slow_d;
  logic              hi_q, hi_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  words_q, words_d;
  logic [SEG_W-1:0]  nseg_q, nseg_d;
  logic [SEG_W-1:0]  seg_q, seg_d;
  logic [1:0]        unused_size_lsb;

  assign unused_size_lsb = size_in[1:0];

  assign empty_in = slow_in ? (size_in[ADDR_W-1:2] == '0)
                            : (size_in[ADDR_W-1:SEG_SHIFT] == '0);

  always_comb begin
    slow_d  = slow_q;
    hi_d    = hi_q;
    base_d  = base_q;
    words_d = words_q;
    nseg_d  = nseg_q;
    seg_d   = seg_q;
    if (load) begin
      slow_d  = slow_in;
      base_d  = base_in;
      words_d = size_in[ADDR_W-1:2];
      nseg_d  = size_in[ADDR_W-1:SEG_SHIFT];
      seg_d   = '0;
      hi_d    = 1'b0;
    end else if (advance) begin
      hi_d = ~hi_q;
      if (hi_q) seg_d = seg_q + SEG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q  <= 1'b0;
      hi_q    <= 1'b0;
      base_q  <= '0;
      words_q <= '0;
      nseg_q  <= '0;
      seg_q   <= '0;
    end else if (load || advance) begin
      slow_q  <= slow_d;
      hi_q    <= hi_d;
      base_q  <= base_d;
      words_q <= words_d;
      nseg_q  <= nseg_d;
      seg_q   <= seg_d;
    end
  end

  assign span_base  = slow_q ? base_q
                             : base_q + {seg_q, {SEG_SHIFT{1'b0}}}
                               + (hi_q ? ADDR_W'(HI_OFF) : '0);
  assign span_words = slow_q ? words_q : IDX_W'(WIN_WORDS);
  assign last_span  = slow_q || (hi_q && (seg_q == nseg_q - SEG_W'(1)));
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import msq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_SHIFT = 20,
  parameter int WIN_BYTES = 2048,
  parameter int KA_LOG    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              slow_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] region_bytes,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              keepalive,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [31:0]       fail_exp,
  output logic [31:0]       fail_got
);
  localparam int IDX_W = ADDR_W - 2;

  seq_st_t           st_q, st_d;
  pat_sel_t          case_q, case_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [31:0]       fexp_q, fexp_d;
  logic [31:0]       fgot_q, fgot_d;

  logic              plan_load, plan_adv, plan_empty, last_span;
  logic [ADDR_W-1:0] span_base;
  logic [IDX_W-1:0]  span_words;
  logic [31:0]       pat_word;
  logic              last_word;

  msq_span_plan #(
    .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .WIN_BYTES(WIN_BYTES)
  ) u_plan (
    .clk(clk), .rst_n(rst_n), .load(plan_load), .slow_in(slow_mode),
    .base_in(base_addr), .size_in(region_bytes), .advance(plan_adv),
    .empty_in(plan_empty), .span_base(span_base), .span_words(span_words),
    .last_span(last_span)
  );

  msq_pattern_gen #(.IDX_W(IDX_W)) u_pat (
    .sel(case_q), .idx(idx_q), .word(pat_word)
  );

  assign last_word = (idx_q == span_words - IDX_W'(1));
  assign busy      = (st_q != ST_IDLE);
  assign mem_en    = (st_q == ST_FILL) || (st_q == ST_READ);
  assign mem_we    = (st_q == ST_FILL);
  assign mem_addr  = span_base + {idx_q, 2'b00};
  assign mem_wdata = pat_word;
  assign keepalive = mem_en && (idx_q[KA_LOG-1:0] == '0);
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_addr = faddr_q;
  assign fail_exp  = fexp_q;
  assign fail_got  = fgot_q;

  always_comb begin
    st_d      = st_q;
    case_d    = case_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    fail_d    = fail_q;
    faddr_d   = faddr_q;
    fexp_d    = fexp_q;
    fgot_d    = fgot_q;
    plan_load = 1'b0;
    plan_adv  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          fail_d    = 1'b0;
          plan_load = 1'b1;
          if (plan_empty) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_FILL;
            case_d = PAT_ZERO;
            idx_d  = '0;
          end
        end
      end
      ST_FILL: begin
        if (last_word) begin
          idx_d = '0;
          st_d  = ST_READ;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_READ: st_d = ST_CHECK;
      ST_CHECK: begin
        if (mem_rdata != pat_word) begin
          fail_d  = 1'b1;
          faddr_d = mem_addr;
          fexp_d  = pat_word;
          fgot_d  = mem_rdata;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end else if (!last_word) begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = ST_READ;
        end else if (case_q != PAT_NINDEX) begin
          case_d = pat_sel_t'(case_q + 3'd1);
          idx_d  = '0;
          st_d   = ST_FILL;
        end else if (!last_span) begin
          plan_adv = 1'b1;
          case_d   = PAT_ZERO;
          idx_d    = '0;
          st_d     = ST_FILL;
        end else begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      case_q  <= PAT_ZERO;
      idx_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else begin
      st_q    <= st_d;
      case_q  <= case_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
      fexp_q  <= fexp_d;
      fgot_q  <= fgot_d;
    end
  end

  // R10: end-of-run pulse lasts one cycle and only when idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);
  // R9: failure record is held until a start is accepted
  a_r9_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);
  a_r9_record_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));
  // R7: progress pulse only on an access
  a_r7_ka_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    keepalive |-> mem_en);
  // R3: each read leaves a compare cycle free of accesses
  a_r3_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> !mem_en);
  a_r3_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);
endmodule

// File: tb/tb_mem_pattern_seq.sv
`timescale 1ns/1ps
module tb_mem_pattern_seq;
  localparam int SEG = 8;
  localparam int WIN = 32;
  localparam int KA  = 4;

  logic        clk, rst_n, start, slow_mode;
  logic [31:0] base_addr, region_bytes;
  logic        busy, done, mem_en, mem_we, keepalive, fail;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fail_addr, fail_exp, fail_got;

  mem_pattern_seq #(.ADDR_W(32), .SEG_SHIFT(SEG), .WIN_BYTES(WIN), .KA_LOG(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slow_mode(slow_mode),
    .base_addr(base_addr), .region_bytes(region_bytes), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .keepalive(keepalive), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model with a data-dependent read fault
  logic [31:0] mem_arr [0:255];
  logic [31:0] mem_raw;
  logic        flt_on;
  logic [31:0] flt_addr, flt_val;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_arr[mem_addr[9:2]] <= mem_wdata;
      else begin
        mem_raw = mem_arr[mem_addr[9:2]];
        mem_rdata <= mem_raw ^ ((flt_on && mem_addr == flt_addr && mem_raw == flt_val)
                                ? 32'h1 : 32'h0);
      end
    end
  end

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    bit          ka;
  } op_t;
  op_t exp_q[$];
  bit  stream_on = 0;
  int  op_cnt = 0;

  function automatic logic [31:0] pat(input int c, input int k);
    case (c)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'h1 << (k % 32);
      5: return 32'(k);
      default: return ~32'(k);
    endcase
  endfunction

  task automatic add_span(input logic [31:0] b, input int n);
    for (int c = 0; c < 7; c++) begin
      for (int k = 0; k < n; k++) exp_q.push_back('{1'b1, b + 32'(4*k), pat(c, k), (k % KA) == 0});
      for (int k = 0; k < n; k++) exp_q.push_back('{1'b0, b + 32'(4*k), 32'h0, (k % KA) == 0});
    end
  endtask

  task automatic build(input bit slow, input logic [31:0] base, input logic [31:0] size);
    exp_q.delete();
    if (slow) add_span(base, int'(size >> 2));
    else
      for (int s = 0; s < int'(size >> SEG); s++) begin
        add_span(base + 32'(s << SEG), WIN / 4);
        add_span(base + 32'(s << SEG) + 32'((1 << SEG) - WIN), WIN / 4);
      end
  endtask

  op_t e;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en) begin
        op_cnt++;
        if (stream_on) begin
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected access", mem_addr, 32'h0);
          else begin
            e = exp_q.pop_front();
            check(mem_we == e.we, "R3 access direction", 32'(mem_we), 32'(e.we));
            check(mem_addr == e.addr, "R5 access address", mem_addr, e.addr);
            if (e.we) check(mem_wdata == e.data, "R2 R6 write data", mem_wdata, e.data);
            check(keepalive == e.ka, "R7 keepalive", 32'(keepalive), 32'(e.ka));
          end
        end
      end else if (keepalive) check(1'b0, "R7 keepalive without access", 32'h1, 32'h0);
    end
  end

  int  r_cycles;
  bit  r_fail_done, r_fail_before, r_busy_first;
  int  r_extra_done;

  task automatic run(input bit slow, input logic [31:0] base, input logic [31:0] size,
                     input bit stream, input int mid);
    bit prevf;
    if (stream) build(slow, base, size);
    stream_on = stream;
    op_cnt = 0;
    @(negedge clk);
    slow_mode = slow; base_addr = base; region_bytes = size; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_cycles = 1;
    r_busy_first = busy;
    prevf = 1'b0;
    while (!done) begin
      if (r_cycles >= 20000) begin
        check(1'b0, "R10 run never ended", 32'(r_cycles), 32'h0);
        break;
      end
      if (r_cycles == mid) begin
        start = 1'b1; slow_mode = ~slow; base_addr = 32'h40; region_bytes = 32'h100;
      end else begin
        start = 1'b0; slow_mode = slow; base_addr = base; region_bytes = size;
      end
      prevf = fail;
      @(negedge clk);
      r_cycles++;
    end
    start = 1'b0;
    r_fail_done = fail;
    r_fail_before = prevf;
    r_extra_done = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) r_extra_done++;
    end
    check(r_extra_done == 0, "R10 done single pulse", 32'(r_extra_done), 32'h0);
    stream_on = 0;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'h0;
    mem_rdata = 32'h0;
    flt_on = 1'b0; flt_addr = 32'h0; flt_val = 32'h0;
    rst_n = 1'b0; start = 1'b0; slow_mode = 1'b0; base_addr = 32'h0; region_bytes = 32'h0;
    repeat (3) @(negedge clk);
    check({busy, done, fail, mem_en, keepalive} == 5'b0, "R1 reset state",
          32'({busy, done, fail, mem_en, keepalive}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, fail, mem_en, keepalive} == 5'b0, "R1 after release",
          32'({busy, done, fail, mem_en, keepalive}), 32'h0);

    // R4 R11: slow mode over whole region, stray start mid-run
    run(1'b1, 32'h0, 32'h400, 1'b1, 300);
    check(r_busy_first, "R10 busy after start", 32'(r_busy_first), 32'h1);
    check(op_cnt == 3584, "R4 R11 slow access count", 32'(op_cnt), 32'd3584);
    check(exp_q.size() == 0, "R3 all accesses seen", 32'(exp_q.size()), 32'h0);
    check(!fail, "R8 clean slow run", 32'(fail), 32'h0);

    // R5: quick mode, aligned base
    run(1'b0, 32'h0, 32'h400, 1'b1, -1);
    check(op_cnt == 896, "R5 quick access count", 32'(op_cnt), 32'd896);
    check(exp_q.size() == 0, "R5 all accesses seen", 32'(exp_q.size()), 32'h0);

    // R5 R6: quick mode, offset base, partial trailing segment ignored
    run(1'b0, 32'h40, 32'h2FF, 1'b1, -1);
    check(op_cnt == 448, "R5 offset quick count", 32'(op_cnt), 32'd448);
    check(exp_q.size() == 0, "R6 offset spans seen", 32'(exp_q.size()), 32'h0);

    // R4 R6: slow mode, size not a word multiple
    run(1'b1, 32'h100, 32'h2E, 1'b1, -1);
    check(op_cnt == 154, "R4 truncated span count", 32'(op_cnt), 32'd154);
    check(exp_q.size() == 0, "R6 truncated span seen", 32'(exp_q.size()), 32'h0);

    // R12: empty regions
    run(1'b0, 32'h0, 32'hFF, 1'b0, -1);
    check(r_cycles == 1 && op_cnt == 0, "R12 quick empty", 32'(r_cycles), 32'h1);
    run(1'b1, 32'h0, 32'h3, 1'b0, -1);
    check(r_cycles == 1 && op_cnt == 0, "R12 slow empty", 32'(r_cycles), 32'h1);
    check(!r_busy_first, "R12 no busy", 32'(r_busy_first), 32'h0);

    // R8: fault in the all-ones case, slow mode
    flt_on = 1'b1; flt_addr = 32'h10; flt_val = 32'hFFFF_FFFF;
    run(1'b1, 32'h0, 32'h400, 1'b1, -1);
    check(op_cnt == 773, "R8 stop at first mismatch", 32'(op_cnt), 32'd773);
    check(fail_addr == 32'h10, "R8 fail address", fail_addr, 32'h10);
    check(fail_exp == 32'hFFFF_FFFF, "R8 fail expected", fail_exp, 32'hFFFF_FFFF);
    check(fail_got == 32'hFFFF_FFFE, "R8 fail read", fail_got, 32'hFFFF_FFFE);
    check(r_fail_done && !r_fail_before, "R10 fail with done", 32'(r_fail_done), 32'h1);
    repeat (5) @(negedge clk);
    check(fail && fail_addr == 32'h10, "R9 fail sticky", 32'(fail), 32'h1);

    // R2 R6: fault in the walking-one case
    flt_addr = 32'h94; flt_val = 32'h20;
    run(1'b1, 32'h0, 32'h400, 1'b1, -1);
    check(op_cnt == 2342, "R2 walking case reached", 32'(op_cnt), 32'd2342);
    check(fail_exp == 32'h20 && fail_got == 32'h21, "R2 walking fail data", fail_got, 32'h21);

    // R10: failure on the very last compare coincides with done
    flt_addr = 32'h3FC; flt_val = 32'hFFFF_FFF8;
    run(1'b0, 32'h0, 32'h400, 1'b1, -1);
    check(op_cnt == 896, "R10 last word access count", 32'(op_cnt), 32'd896);
    check(r_fail_done && !r_fail_before, "R10 same-cycle fail and done", 32'(r_fail_done), 32'h1);
    check(fail_addr == 32'h3FC, "R8 last fail address", fail_addr, 32'h3FC);
    check(fail_exp == 32'hFFFF_FFF8 && fail_got == 32'hFFFF_FFF9, "R2 inverse index fail",
          fail_got, 32'hFFFF_FFF9);

    // R9: accepted start clears fail
    flt_on = 1'b0;
    @(negedge clk);
    slow_mode = 1'b0; base_addr = 32'h0; region_bytes = 32'h100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!fail && busy, "R9 start clears fail", 32'(fail), 32'h0);
    while (!done) @(negedge clk);
    check(!fail, "R9 clean rerun", 32'(fail), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule